// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial characters. An enable tick, `rt_tick`, runs at sixteen times the bit rate. Each tick divides a bit cell into sixteen slots, numbered 1 to 16. While the line is idle the receiver watches for a high-to-low change between two ticks. It treats the tick that first sees the line low as slot 1 of the start cell. From then on it counts slots and bit cells.

Every cell, including the start and stop cells, is sampled at slots 8, 9 and 10. The bit value is the majority of those three samples. Any disagreement among the three samples marks the character as noisy. A start cell that votes high is treated as a glitch and produces nothing. Characters carry 8 or 9 data bits, least significant first, and the length is chosen by a mode input that is latched at the start edge.

Once the stop samples have been taken, the receiver presents the word with a one-cycle strobe, a noise flag and a framing flag. It then hunts for the next edge straight away. A following character may therefore begin in slot 11 of the stop cell. Baud generation, parity and buffering are outside the block.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `valid_o`, `noise_err_o`, `frame_err_o` and `data_o` are 0. While the line stays high, no strobe appears.
- R2: A start cell whose samples at slots 8, 9 and 10 vote high is dropped as a glitch. No strobe is produced for it, and the receiver returns to hunting for an edge.
- R3: Each cell is sampled at slots 8, 9 and 10 counted from the detected edge (slot 1). The bit value is the majority of those three samples.
- R4: Data bits arrive least significant first. In 8-bit mode the word sits in `data_o[7:0]` and `data_o[8]` is 0. `data_o` changes only together with the strobe.
- R5: With `nine_bit` = 1 at the start edge, nine data bits are received into `data_o[8:0]`, and the stop cell follows the ninth bit.
- R6: `noise_err_o` is 1 for a character if the three samples of any of its cells (start, data or stop) do not all agree. It is 0 otherwise.
- R7: `frame_err_o` is 1 when the stop cell votes 0. The word is still presented with the strobe.
- R8: `valid_o` is a one-cycle pulse. It follows the tick that is 154 ticks after the edge (the edge tick counting as 1) for 8-bit characters, and 170 ticks for 9-bit characters.
- R9: After the stop samples, the receiver accepts a new start edge from slot 11 of the stop cell onward.
- R10: Characters whose cells are about 4.4% longer or about 3.75% shorter than nominal are received with correct data and with neither flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_tick | input | 1 | Slot enable, sixteen per bit time |
| rxd | input | 1 | Serial line, already synchronous to `clk` |
| nine_bit | input | 1 | 1 selects nine data bits, sampled at the start edge |
| data_o | output | 9 | Received word |
| valid_o | output | 1 | One-cycle strobe for a completed character |
| noise_err_o | output | 1 | Some cell had disagreeing samples |
| frame_err_o | output | 1 | Stop cell voted 0 |

## Verification
Nominal 8-bit and 9-bit frames with differing bit patterns separate errors in bit order, word placement and the strobe's tick position. A frame with a single flipped sample tells the noise flag apart from the data vote, since the word must stay intact. A low stop cell checks the framing flag, and a three-tick low pulse shows that glitches are dropped. Frames stretched and compressed by a fractional cell length probe the sampling window at both edges. The compressed frame is followed at once by another character, which shows that a start in slot 11 of the stop cell is caught.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // majority of three samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // samples disagree
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (a ^ c);
  endfunction
endpackage

// File: rtl/rx_slot_timer.sv
module rx_slot_timer #(
  parameter int OVS = 16,
  parameter int CELLS_MAX = 11,
  localparam int RTW = $clog2(OVS + 1),
  localparam int BW = $clog2(CELLS_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rt_tick,
  input  logic           start,
  input  logic           active,
  output logic [RTW-1:0] slot_now,
  output logic [BW-1:0]  cell_now
);
  logic [RTW-1:0] rt_q;
  logic [BW-1:0]  cell_q;

  // position of the current tick
  always_comb begin
    if (rt_q == RTW'(OVS)) begin
      slot_now = RTW'(1);
      cell_now = cell_q + BW'(1);
    end else begin
      slot_now = rt_q + RTW'(1);
      cell_now = cell_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q   <= '0;
      cell_q <= '0;
    end else if (rt_tick) begin
      if (start) begin
        rt_q   <= RTW'(1);
        cell_q <= '0;
      end else if (active) begin
        rt_q   <= slot_now;
        cell_q <= cell_now;
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rt_q >= RTW'(1) && rt_q <= RTW'(OVS))); // R3
  AST_CELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cell_q < BW'(CELLS_MAX))); // R8
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 #(
  parameter int OVS = 16,
  parameter int MID = 9,
  localparam int RTW = $clog2(OVS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rt_tick,
  input  logic           active,
  input  logic [RTW-1:0] slot_now,
  input  logic           rxd,
  output logic           cell_done,
  output logic           bit_val,
  output logic           bit_noisy
);
  import uart_rx_pkg::*;
  localparam int S_LO = MID - 1;
  localparam int S_HI = MID + 1;

  logic [1:0] early_q;
  logic       take_lo, take_mid;

  assign take_lo   = rt_tick && active && slot_now == RTW'(S_LO);
  assign take_mid  = rt_tick && active && slot_now == RTW'(MID);
  assign cell_done = rt_tick && active && slot_now == RTW'(S_HI);
  assign bit_val   = maj3(early_q[0], early_q[1], rxd);
  assign bit_noisy = split3(early_q[0], early_q[1], rxd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) early_q <= 2'b11;
    else begin
      if (take_lo)  early_q[0] <= rxd;
      if (take_mid) early_q[1] <= rxd;
    end
  end

  AST_VOTE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |-> !$past(cell_done)); // R3
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OVS = 16,
  parameter int MID = 9,
  parameter int DATA_MAX = 9,
  localparam int CELLS_MAX = DATA_MAX + 2,
  localparam int RTW = $clog2(OVS + 1),
  localparam int BW = $clog2(CELLS_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rt_tick,
  input  logic                rxd,
  input  logic                nine_bit,
  output logic [DATA_MAX-1:0] data_o,
  output logic                valid_o,
  output logic                noise_err_o,
  output logic                frame_err_o
);
  logic                busy_q, prev_q, mode_q, noise_acc;
  logic [DATA_MAX-1:0] shift_q;
  logic [RTW-1:0]      slot_now;
  logic [BW-1:0]       cell_now, stop_cell;
  logic                start_det, cell_done, bit_val, bit_noisy;
  logic                start_fail, stop_done, data_take;

  // place the shifted word according to length
  function automatic logic [DATA_MAX-1:0] place_word(input logic [DATA_MAX-1:0] sh,
                                                     input logic full);
    return full ? sh : {1'b0, sh[DATA_MAX-1:1]};
  endfunction

  assign start_det  = rt_tick && !busy_q && prev_q && !rxd;
  assign stop_cell  = mode_q ? BW'(DATA_MAX + 1) : BW'(DATA_MAX);
  assign start_fail = cell_done && cell_now == '0 && bit_val;
  assign stop_done  = cell_done && cell_now == stop_cell;
  assign data_take  = cell_done && cell_now != '0 && cell_now != stop_cell;

  rx_slot_timer #(.OVS(OVS), .CELLS_MAX(CELLS_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .start(start_det),
    .active(busy_q), .slot_now(slot_now), .cell_now(cell_now));

  rx_vote3 #(.OVS(OVS), .MID(MID)) u_vote (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .active(busy_q),
    .slot_now(slot_now), .rxd(rxd), .cell_done(cell_done),
    .bit_val(bit_val), .bit_noisy(bit_noisy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      prev_q    <= 1'b1;
      mode_q    <= 1'b0;
      noise_acc <= 1'b0;
      shift_q   <= '0;
    end else begin
      if (rt_tick && !busy_q) prev_q <= rxd;
      if (start_det) begin
        busy_q    <= 1'b1;
        mode_q    <= nine_bit;
        noise_acc <= 1'b0;
      end
      if (cell_done) noise_acc <= noise_acc | bit_noisy;
      if (data_take) shift_q <= {bit_val, shift_q[DATA_MAX-1:1]};
      if (start_fail || stop_done) begin
        busy_q <= 1'b0;
        prev_q <= rxd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      noise_err_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= stop_done;
      if (stop_done) begin
        data_o      <= place_word(shift_q, mode_q);
        noise_err_o <= noise_acc | bit_noisy;
        frame_err_o <= !bit_val;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R8
  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rt_tick)); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o)); // R4
  AST_SHORT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !mode_q) |-> !data_o[DATA_MAX-1]); // R4
  AST_GLITCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> (!valid_o && !busy_q)); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(frame_err_o) && $stable(noise_err_o))); // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !busy_q); // R9
endmodule

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rt_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0;
  logic [8:0] data_o;
  logic       valid_o, noise_err_o, frame_err_o;

  int n_checks = 0;
  int n_fail = 0;
  int tick_no = 0;
  int clk_no = 0;
  bit done = 1'b0;

  typedef struct {
    logic [8:0] data;
    logic       noise;
    logic       frame;
    int         at_tick;
    string      tag;
  } item_t;
  item_t sb[$];

  uart_os_rx dut (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd), .nine_bit(nine_bit),
    .data_o(data_o), .valid_o(valid_o), .noise_err_o(noise_err_o),
    .frame_err_o(frame_err_o));

  always #4 clk = ~clk;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick(input logic v);
    @(negedge clk);
    rxd = v;
    rt_tick = 1'b1;
    tick_no++;
    @(negedge clk);
    rt_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b1);
  endtask

  // cell of tick t is floor((t-1)*num/den); nominal is num=1, den=16
  task automatic send(input logic [8:0] d, input bit nine, input int num, input int den,
                      input bit stop_v, input int flip_t, input string tag);
    int nb, span;
    item_t it;
    nb = nine ? 9 : 8;
    span = ((nb + 2) * den + num - 1) / num;
    nine_bit = nine;
    it.data = nine ? d : {1'b0, d[7:0]};
    it.noise = (flip_t > 0);
    it.frame = !stop_v;
    it.at_tick = tick_no + (nine ? 170 : 154);
    it.tag = tag;
    sb.push_back(it);
    for (int t = 1; t <= span; t++) begin
      int b;
      logic v;
      b = ((t - 1) * num) / den;
      if (b == 0) v = 1'b0;
      else if (b <= nb) v = d[b-1];
      else if (b == nb + 1) v = stop_v;
      else v = 1'b1;
      if (t == flip_t) v = ~v;
      do_tick(v);
    end
  endtask

  // monitor: pops expected items as characters arrive
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        check("R2 unexpected strobe", 1'b0, int'(data_o), 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        check({e.tag, " data R4"}, data_o == e.data, int'(data_o), int'(e.data));
        check({e.tag, " noise R6"}, noise_err_o == e.noise, int'(noise_err_o), int'(e.noise));
        check({e.tag, " frame R7"}, frame_err_o == e.frame, int'(frame_err_o), int'(e.frame));
        check({e.tag, " tick R8"}, tick_no == e.at_tick, tick_no, e.at_tick);
      end
    end
  end

  always @(posedge clk) begin
    clk_no++;
    if (clk_no > 150000 && !done) begin
      done = 1'b1;
      check("watchdog", 1'b0, clk_no, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", valid_o == 1'b0, int'(valid_o), 0);
    check("R1 reset data", data_o == 9'h0, int'(data_o), 0);
    check("R1 reset flags", {noise_err_o, frame_err_o} == 2'b00,
          int'({noise_err_o, frame_err_o}), 0);
    idle(40);
    check("R1 idle no strobe", sb.size() == 0, sb.size(), 0);

    send(9'h0A5, 1'b0, 1, 16, 1'b1, 0, "R3 nominal 8-bit A5");
    idle(5);
    // single flipped sample at slot 9 of data bit 2
    send(9'h03C, 1'b0, 1, 16, 1'b1, 57, "R6 noisy sample 3C");
    idle(5);
    // R2: three-tick low pulse, dropped
    do_tick(1'b0); do_tick(1'b0); do_tick(1'b0);
    idle(20);
    check("R2 glitch dropped", sb.size() == 0, sb.size(), 0);
    send(9'h081, 1'b0, 1, 16, 1'b1, 0, "R2 after glitch 81");
    idle(5);
    send(9'h1B6, 1'b1, 1, 16, 1'b1, 0, "R5 nominal 9-bit 1B6");
    idle(5);
    send(9'h055, 1'b0, 1, 16, 1'b0, 0, "R7 low stop 55");
    idle(10);
    send(9'h0C3, 1'b0, 10, 167, 1'b1, 0, "R10 slow 8-bit C3");
    idle(5);
    send(9'h12D, 1'b1, 10, 167, 1'b1, 0, "R10 slow 9-bit 12D");
    idle(5);
    // R9: fast frame followed at once by the next start
    send(9'h05A, 1'b0, 10, 154, 1'b1, 0, "R10 fast 8-bit 5A");
    send(9'h00F, 1'b0, 1, 16, 1'b1, 0, "R9 back-to-back 0F");
    idle(20);
    check("R8 all strobes seen", sb.size() == 0, sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule